// File: doc/BRIEF.md
# Five-Channel Reloadable Down-Counter Timer

This block is a bank of five independent 32-bit down-counting timers behind a small memory-mapped register file. A single shared control word holds one bit field per channel. Each channel has a count buffer, a compare buffer, a read-only view of its live counter and its own interrupt line. Software first writes the count buffer. It then sets the channel's manual-update bit, which copies the buffer into the live counter. Finally, in one write, it clears manual-update and sets start. The counter then steps down once per tick, and a tick occurs on every second bus clock.

When a running counter sits at zero and a tick arrives, the channel expires and raises its pending interrupt flag. With auto-reload set, the counter reloads from the count buffer and keeps going. With auto-reload clear, the counter stays at zero and the hardware clears the channel's start bit. A period of N ticks is programmed by writing N−1 into the count buffer.

Writes take effect at the clock edge that samples them. Reads are combinational from the address.

Top module: `mtb_bank`

## Requirements
- R1: Channels 0 to 3 have their count buffer at byte offset 0x0C+0x0C·n and their compare buffer at 0x10+0x0C·n. Channel 4 has its count buffer at 0x3C and its compare buffer at 0x48. All buffers are 32-bit and read back what was written.
- R2: The control word sits at 0x08. Channel 0 uses bits [3:0], channel 1 bits [11:8], channel 2 bits [15:12] and channel 3 bits [19:16]. In these 4-bit fields, bit 0 is start, bit 1 is manual update, bit 2 is a stored invert flag and bit 3 is auto-reload. Channel 4 uses bits [22:20], holding start, manual update and auto-reload from low to high. All other control bits read as 0.
- R3: While its start bit is clear and manual update is clear, a channel's counter holds its value. The other channels are unaffected.
- R4: On every clock in which a channel's manual-update bit is set, the counter takes the count buffer value. This overrides counting.
- R5: A started channel with auto-reload set expires on the tick that finds the counter at zero and reloads from the count buffer. With a buffer of N−1, expiries are N ticks apart.
- R6: A started channel with auto-reload clear expires once and stays at zero, and the hardware clears its start bit in the same clock.
- R7: The live counter of channel n (0 to 3) reads at 0x14+0x0C·n, and channel 4's reads at 0x40. A buffer of 0xFFFFFFFF loads and counts down as a full 32-bit value.
- R8: irq_o[n] is a sticky pending flag set by an expiry of channel n. Writing 1 to bit n at 0x44 clears it, and bits written as 0 leave their flags alone. When an expiry and a clear fall in the same clock, the expiry wins. The pending flags also read at 0x44.
- R9: A tick occurs on every second clock after reset. A started counter changes only on tick clocks.
- R10: After reset all registers, counters and interrupt flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 5 | Per-channel pending interrupt flags, channel 0 at bit 0 |

## Verification
The bench drives five kinds of traffic. A short periodic channel measures the spacing between expiries, which separates correct reload and divide-by-two timing from off-by-one periods. A one-shot channel shows whether the start bit is cleared and whether the flag stays quiet afterwards. A halted channel next to a running one exposes any cross-channel coupling in the shared control word. A zero-length periodic channel is hit with a clear on every clock, which forces the case where a clear and an expiry fall in the same clock. A free-running full-width counter and control writes with junk in the unused bits check the extreme buffer value and the field masking.

// File: rtl/mtb_pkg.sv
package mtb_pkg;

    localparam int unsigned NCH      = 5;
    localparam int unsigned NARROW_W = 3;
    localparam int unsigned WIDE_W   = 4;
    localparam logic [7:0]  CTL_ADDR  = 8'h08;
    localparam logic [7:0]  STAT_ADDR = 8'h44;

    // lowest bit of a channel's control field
    function automatic int unsigned fld_lsb(int unsigned ch);
        return (ch == 0) ? 0 : 4 + 4 * ch;
    endfunction

    // auto-reload position: the last channel has the narrow field
    function automatic int unsigned fld_reload(int unsigned ch);
        return (ch == NCH - 1) ? fld_lsb(ch) + 2 : fld_lsb(ch) + 3;
    endfunction

    function automatic logic [7:0] cnt_addr(int unsigned ch);
        return (ch == NCH - 1) ? 8'h3C : 8'(12 + 12 * ch);
    endfunction

    function automatic logic [7:0] cmp_addr(int unsigned ch);
        return (ch == NCH - 1) ? 8'h48 : 8'(16 + 12 * ch);
    endfunction

    function automatic logic [7:0] obs_addr(int unsigned ch);
        return (ch == NCH - 1) ? 8'h40 : 8'(20 + 12 * ch);
    endfunction

    function automatic logic [31:0] ctl_mask();
        logic [31:0] m;
        m = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int b = 0; b < ((c == NCH - 1) ? NARROW_W : WIDE_W); b++) begin
                m[fld_lsb(c) + b] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/mtb_tick.sv
module mtb_tick (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    typedef struct packed {
        logic phase;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.phase = ~s_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.phase;

    // R9: tick alternates every clock
    p_tick_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    p_tick_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> tick_o);

endmodule

// File: rtl/mtb_channel.sv
module mtb_channel #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          start_i,
    input  logic          load_i,
    input  logic          reload_i,
    input  logic [CW-1:0] buf_i,
    output logic [CW-1:0] cnt_o,
    output logic          expire_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } ch_st_t;

    ch_st_t s_d, s_q;
    logic   expire_d;

    always_comb begin
        s_d      = s_q;
        expire_d = 1'b0;
        if (load_i) begin
            s_d.cnt = buf_i;
        end else if (start_i && tick_i) begin
            if (s_q.cnt == '0) begin
                expire_d = 1'b1;
                s_d.cnt  = reload_i ? buf_i : '0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o    = s_q.cnt;
    assign expire_o = expire_d;

    // R4: manual update copies the buffer
    p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(buf_i)));
    // R3: halted counter holds
    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !load_i) |=> $stable(cnt_o));
    // R5: periodic expiry reloads
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && reload_i) |=> (cnt_o == $past(buf_i)));
    // R6: one-shot expiry parks at zero
    p_oneshot_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !reload_i) |=> (cnt_o == '0));
    // R9: no change off-tick
    p_offtick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_o));

endmodule

// File: rtl/mtb_bank.sv
module mtb_bank
    import mtb_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NCH-1:0] irq_o
);
    localparam logic [DW-1:0] CTL_MASK = DW'(ctl_mask());

    typedef struct packed {
        logic [DW-1:0]           ctl;
        logic [NCH-1:0][DW-1:0]  cbuf;
        logic [NCH-1:0][DW-1:0]  mbuf;
        logic [NCH-1:0]          pend;
    } regs_t;

    regs_t s_d, s_q;

    logic                   tick;
    logic [NCH-1:0]         start_w, load_w, reload_w, expire_w;
    logic [NCH-1:0][DW-1:0] cnt_w;
    logic [NCH-1:0]         clr_vec;

    mtb_tick u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int unsigned LSB = fld_lsb(c);
        localparam int unsigned RLB = fld_reload(c);

        assign start_w[c]  = s_q.ctl[LSB];
        assign load_w[c]   = s_q.ctl[LSB + 1];
        assign reload_w[c] = s_q.ctl[RLB];

        mtb_channel #(.CW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick),
            .start_i  (start_w[c]),
            .load_i   (load_w[c]),
            .reload_i (reload_w[c]),
            .buf_i    (s_q.cbuf[c]),
            .cnt_o    (cnt_w[c]),
            .expire_o (expire_w[c])
        );

        // R6: one-shot expiry drops the start bit
        p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (expire_w[c] && !reload_w[c]) |=> !start_w[c]);
    end

    always_comb begin
        s_d     = s_q;
        clr_vec = '0;
        if (bus_wr) begin
            if (bus_addr == CTL_ADDR)  s_d.ctl = bus_wdata & CTL_MASK;
            if (bus_addr == STAT_ADDR) clr_vec = bus_wdata[NCH-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == cnt_addr(c)) s_d.cbuf[c] = bus_wdata;
                if (bus_addr == cmp_addr(c)) s_d.mbuf[c] = bus_wdata;
            end
        end
        for (int c = 0; c < NCH; c++) begin
            if (expire_w[c] && !reload_w[c]) s_d.ctl[fld_lsb(c)] = 1'b0;
        end
        s_d.pend = (s_q.pend & ~clr_vec) | expire_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTL_ADDR)  bus_rdata = s_q.ctl;
        if (bus_addr == STAT_ADDR) bus_rdata = {{(DW-NCH){1'b0}}, s_q.pend};
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == cnt_addr(c)) bus_rdata = s_q.cbuf[c];
            if (bus_addr == cmp_addr(c)) bus_rdata = s_q.mbuf[c];
            if (bus_addr == obs_addr(c)) bus_rdata = cnt_w[c];
        end
    end

    assign irq_o = s_q.pend;

    // R8: pending flags survive unless cleared
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.pend & ~clr_vec) != '0)
        |=> ((irq_o & $past(s_q.pend & ~clr_vec)) == $past(s_q.pend & ~clr_vec)));
    // R8: an expiry always lands, even against a clear
    p_expiry_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_w != '0) |=> ((irq_o & $past(expire_w)) == $past(expire_w)));

endmodule

// File: tb/tb_mtb_bank.sv
module tb_mtb_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  irq_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    mtb_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #5 clk = ~clk;

    // ---- behavioural reference model ----
    localparam logic [31:0] MASK = 32'h007F_FF0F;
    logic [31:0] m_ctl, m_nctl;
    logic [31:0] m_buf [5];
    logic [31:0] m_cmp [5];
    logic [31:0] m_cnt [5];
    logic [4:0]  m_pend, m_exp, m_clr;
    logic        m_tick;

    function automatic int lsb(int c);   return (c == 0) ? 0 : 4 + 4 * c; endfunction
    function automatic int rlb(int c);   return (c == 4) ? lsb(c) + 2 : lsb(c) + 3; endfunction
    function automatic logic [7:0] a_cnt(int c); return (c == 4) ? 8'h3C : 8'(12 + 12 * c); endfunction
    function automatic logic [7:0] a_cmp(int c); return (c == 4) ? 8'h48 : 8'(16 + 12 * c); endfunction
    function automatic logic [7:0] a_obs(int c); return (c == 4) ? 8'h40 : 8'(20 + 12 * c); endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_ctl = '0; m_pend = '0; m_tick = 1'b0;
            for (int c = 0; c < 5; c++) begin
                m_buf[c] = '0; m_cmp[c] = '0; m_cnt[c] = '0;
            end
        end else begin
            m_nctl = m_ctl; m_exp = '0; m_clr = '0;
            for (int c = 0; c < 5; c++) begin
                if (m_ctl[lsb(c) + 1]) m_cnt[c] = m_buf[c];
                else if (m_ctl[lsb(c)] && m_tick) begin
                    if (m_cnt[c] == 0) begin
                        m_exp[c] = 1'b1;
                        m_cnt[c] = m_ctl[rlb(c)] ? m_buf[c] : 32'd0;
                        if (!m_ctl[rlb(c)]) m_nctl[lsb(c)] = 1'b0;
                    end else m_cnt[c] = m_cnt[c] - 1;
                end
            end
            if (bus_wr) begin
                if (bus_addr == 8'h08) m_nctl = (bus_wdata & MASK) & ~oneshot_clear(m_exp);
                if (bus_addr == 8'h44) m_clr = bus_wdata[4:0];
                for (int c = 0; c < 5; c++) begin
                    if (bus_addr == a_cnt(c)) m_buf[c] = bus_wdata;
                    if (bus_addr == a_cmp(c)) m_cmp[c] = bus_wdata;
                end
            end
            m_ctl  = m_nctl;
            m_pend = (m_pend & ~m_clr) | m_exp;
            m_tick = !m_tick;
        end
    end

    function automatic logic [31:0] oneshot_clear(logic [4:0] ex);
        logic [31:0] r;
        r = '0;
        for (int c = 0; c < 5; c++)
            if (ex[c] && !m_ctl[rlb(c)]) r[lsb(c)] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] mread(logic [7:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 8'h08) v = m_ctl;
        if (a == 8'h44) v = {27'd0, m_pend};
        for (int c = 0; c < 5; c++) begin
            if (a == a_cnt(c)) v = m_buf[c];
            if (a == a_cmp(c)) v = m_cmp[c];
            if (a == a_obs(c)) v = m_cnt[c];
        end
        return v;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R8 R5 R9: per-clock comparison of interrupt lines with the model
    always @(negedge clk) begin
        if (rst_n && !done) chk({27'd0, irq_o}, {27'd0, m_pend}, "R8 per-cycle irq");
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
        chk(v, mread(a), tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(8'h08, "R10 ctl reset", v);   chk(v, 32'h0, "R10 ctl zero");
        rd(8'h14, "R10 obs0 reset", v);  chk(v, 32'h0, "R10 obs0 zero");
        chk({27'd0, irq_o}, 32'h0, "R10 irq zero");

        // R1 buffer read-back
        for (int c = 0; c < 5; c++) begin
            wr(a_cnt(c), 32'h1000 + c);
            wr(a_cmp(c), 32'hC0DE_0000 + c);
        end
        for (int c = 0; c < 5; c++) begin
            rd(a_cnt(c), "R1 count buffer", v); chk(v, 32'h1000 + c, "R1 count literal");
            rd(a_cmp(c), "R1 compare buffer", v); chk(v, 32'hC0DE_0000 + c, "R1 compare literal");
        end

        // R4 R5 R9: ch0 periodic N=4, ch2 long periodic
        wr(8'h0C, 32'd3);
        wr(8'h24, 32'd1000);
        wr(8'h08, 32'h0000_2002);
        repeat (3) @(negedge clk);
        rd(8'h14, "R4 obs0 after load", v); chk(v, 32'd3, "R4 load literal");
        wr(8'h08, 32'h0000_9009);
        while (!irq_o[0]) @(negedge clk);
        t1 = cyc;
        wr(8'h44, 32'h1);
        while (!irq_o[0]) @(negedge clk);
        t2 = cyc;
        chk(t2 - t1, 32'd8, "R5 R9 periodic spacing 4 ticks");

        // R3 halt ch0, ch2 keeps running
        wr(8'h08, 32'h0000_9008);
        rd(8'h14, "R3 obs0 a", v);
        rd(8'h2C, "R3 obs2 a", v2);
        repeat (5) @(negedge clk);
        begin
            logic [31:0] w, w2;
            rd(8'h14, "R3 obs0 b", w);  chk(w, v, "R3 halted counter holds");
            rd(8'h2C, "R3 obs2 b", w2); chk(w2, v2 - 3, "R3 other channel runs");
        end

        // R6 one-shot ch1
        wr(8'h18, 32'd5);
        wr(8'h44, 32'h1F);
        wr(8'h08, 32'h0000_9208);
        wr(8'h08, 32'h0000_9108);
        repeat (20) @(negedge clk);
        rd(8'h08, "R6 ctl after one-shot", v); chk(v, 32'h0000_9008, "R6 start cleared");
        rd(8'h20, "R6 obs1", v); chk(v, 32'd0, "R6 parked at zero");
        chk({31'd0, irq_o[1]}, 32'd1, "R6 expiry flagged");
        wr(8'h44, 32'h2);
        repeat (20) @(negedge clk);
        chk({31'd0, irq_o[1]}, 32'd0, "R6 single expiry");

        // R4 manual held with start
        wr(8'h08, 32'h0000_9308);
        repeat (4) @(negedge clk);
        rd(8'h20, "R4 obs1 held a", v); chk(v, 32'd5, "R4 held literal a");
        repeat (5) @(negedge clk);
        rd(8'h20, "R4 obs1 held b", v); chk(v, 32'd5, "R4 held literal b");

        // R2 R7 ch4 narrow field, masking, full-width counter
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h08, 32'h80A0_9388);
        rd(8'h08, "R2 ctl masked", v); chk(v, 32'h0020_9308, "R2 mask literal");
        rd(8'h40, "R7 obs4 max", v); chk(v, 32'hFFFF_FFFF, "R7 max load");
        wr(8'h08, 32'h0050_9308);
        repeat (10) @(negedge clk);
        rd(8'h40, "R7 obs4 running", v);
        chk({31'd0, (v < 32'hFFFF_FFFF && v > 32'hFFFF_FF00)}, 32'd1, "R7 full-width down count");

        // R8 clear vs expiry collision on ch3 (buffer 0, periodic)
        wr(8'h30, 32'd0);
        wr(8'h08, 32'h0052_9308);
        wr(8'h08, 32'h0059_9308);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h8;
        repeat (12) @(negedge clk);
        bus_wr = 1'b0;
        repeat (4) @(negedge clk);
        chk({31'd0, irq_o[3]}, 32'd1, "R8 expiry wins over clear");
        wr(8'h08, 32'h0050_9308);
        repeat (4) @(negedge clk);
        rd(8'h44, "R8 status before clear", v);
        wr(8'h44, 32'h8);
        rd(8'h44, "R8 status after clear", v2);
        chk({31'd0, v2[3]}, 32'd0, "R8 W1C bit3");
        chk(v2 & 32'h17, mread(8'h44) & 32'h17, "R8 other flags untouched");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule